// File: doc/BRIEF.md
# Dual-Section Phase-Frequency Comparator with Lock Qualification

This block sits between the reference and feedback dividers of two frequency-synthesis loops and the charge pumps that steer their oscillators. Each section receives one-cycle strobes from its divided reference and its divided feedback. It measures, in cycles of the reference-oscillator clock, how far one strobe leads the other. While the error lasts it asks the pump to source or sink current. When the two strobes coincide it leaves the pump floating. A per-section polarity input chooses which drive level means "raise the oscillator frequency", so loops with either tuning slope can be served.

Each section also runs a lock qualifier. Any error that has been driven for a few oscillator cycles marks the loop unlocked at once. Lock is declared only after a run of consecutive comparisons whose errors all stayed inside a wider window. The two section results are reduced to one lock output.

A section that is put to sleep stops comparing, floats its pump, holds its lock state and counts as locked in the combined result. The first comparison after reset or after waking has its drive clipped to a few cycles. A random start phase therefore cannot kick the loop far off frequency. The lock qualifier still sees the full error during that comparison.

Top module: `pfd_lock_pair`

## Requirements
- R1: While reset is held and just after it, pump_oe and pump_lvl are 0 for both sections and each section's lock state is clear, so lock_all is 0 whenever any section is awake.
- R2: With pol=1 the pump is driven high (pump_lvl=1) while the reference strobe leads and driven low while the feedback strobe leads.
- R3: With pol=0 the two drive levels of R2 are swapped.
- R4: The pump is driven (pump_oe=1) for exactly as many clock cycles as separate the leading strobe from the lagging one. Coincident strobes produce no drive. pump_lvl is 0 whenever pump_oe is 0.
- R5: A second strobe on the leading input while a comparison is still open neither restarts nor ends that comparison.
- R6: Once the pump of an awake section has been driven for LOSS_CYC (4) cycles of one comparison, that section's lock state clears at the next clock edge.
- R7: A section's lock state is set only at the end of a comparison whose width is below LOSS_CYC, and only when that comparison and the QUAL_CNT-1 (2) before it each had a width below QUAL_CYC (8). A comparison of width QUAL_CYC or more restarts the run.
- R8: lock_all is the AND over sections, where a section counts as locked if its lock state is set or it is asleep (awake=0).
- R9: A sleeping section never drives its pump, not even in the cycle it is put to sleep. It ignores its strobes, abandons any open comparison and keeps its lock state unchanged.
- R10: In the first comparison after reset or after waking, drive stops after WAKE_CAP (2) cycles. The lock qualifier still uses the full width of that comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-oscillator clock; all timing is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stb | input | NSEC | One-cycle strobe per section from the divided reference |
| fb_stb | input | NSEC | One-cycle strobe per section from the divided feedback |
| pol | input | NSEC | Per-section drive polarity (1: reference leading drives high) |
| awake | input | NSEC | Per-section run enable; 0 puts the section to sleep |
| pump_oe | output | NSEC | Pump drive enable; 0 means the pump output floats |
| pump_lvl | output | NSEC | Pump drive level, valid while pump_oe is 1 |
| lock_all | output | 1 | Combined lock indication of all sections |

## Verification
The bench first goes after the width boundaries. A comparison of width 4 must clear lock and one of width 3 must not. A width-8 error must break the qualifying run, while a width of 5 to 7 must count toward it even though it drops lock. A design with an off-by-one window would lock early or late on these sequences. The bench also samples lock in the middle of a long pulse, one cycle before and at the edge of the drop, which catches a qualifier that only acts at the end of a comparison. It sleeps a section in mid-pulse while it is locked, then checks that the pump floats at once, that strobes are ignored and that lock survives. It also checks that only the first comparison after waking is clipped. Finally it locks one section while the other wakes unlocked, which exposes a combiner that ignores the sleep rule or ORs the sections together.

// File: rtl/pfdl_pkg.sv
package pfdl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_UP   = 2'd1,
    PH_DN   = 2'd2
  } ph_state_e;

  // Width needed to hold values 0..maxv.
  function automatic int cnt_width(input int maxv);
    return $clog2(maxv + 1);
  endfunction

  // Pump level for a given open-comparison direction and polarity.
  function automatic logic pump_level(input logic up, input logic dn, input logic pol);
    return pol ? up : dn;
  endfunction

  // Drive window while clipped after wake: cycles 1..cap of a pulse pass.
  function automatic logic wake_pass(input logic clipped, input int cyc, input int cap);
    return !clipped || (cyc <= cap);
  endfunction

endpackage

// File: rtl/pfdl_phase_det.sv
module pfdl_phase_det
  import pfdl_pkg::*;
#(
  parameter int SAT_MAX = 8,
  localparam int CW = cnt_width(SAT_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ref_stb,
  input  logic          fb_stb,
  output logic          up,
  output logic          dn,
  output logic          active,
  output logic [CW-1:0] err_cnt,
  output logic          done,
  output logic [CW-1:0] done_width
);

  ph_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    done       = 1'b0;
    done_width = '0;
    cnt_inc    = (cnt_q == CW'(SAT_MAX)) ? cnt_q : cnt_q + 1'b1;
    if (!en) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        PH_IDLE: begin
          if (ref_stb && fb_stb) begin
            done = 1'b1;
          end else if (ref_stb) begin
            st_d  = PH_UP;
            cnt_d = CW'(1);
          end else if (fb_stb) begin
            st_d  = PH_DN;
            cnt_d = CW'(1);
          end
        end
        PH_UP: begin
          if (fb_stb) begin
            done       = 1'b1;
            done_width = cnt_q;
            st_d       = ref_stb ? PH_UP : PH_IDLE;
            cnt_d      = ref_stb ? CW'(1) : '0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
        PH_DN: begin
          if (ref_stb) begin
            done       = 1'b1;
            done_width = cnt_q;
            st_d       = fb_stb ? PH_DN : PH_IDLE;
            cnt_d      = fb_stb ? CW'(1) : '0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
        default: begin
          st_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign up      = (st_q == PH_UP);
  assign dn      = (st_q == PH_DN);
  assign active  = up | dn;
  assign err_cnt = cnt_q;

endmodule

// File: rtl/pfdl_lock_qual.sv
module pfdl_lock_qual
  import pfdl_pkg::*;
#(
  parameter int LOSS_CYC = 4,
  parameter int QUAL_CYC = 8,
  parameter int QUAL_CNT = 3,
  localparam int CW = cnt_width(QUAL_CYC),
  localparam int SW = cnt_width(QUAL_CNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          active,
  input  logic [CW-1:0] err_cnt,
  input  logic          done,
  input  logic [CW-1:0] done_width,
  output logic          locked,
  output logic          drop
);

  logic [SW-1:0] run_q, run_d;
  logic          good, bad, locked_q;

  assign drop = en && active && (err_cnt >= CW'(LOSS_CYC));
  assign good = en && done && (done_width < CW'(QUAL_CYC));
  assign bad  = en && done && !(done_width < CW'(QUAL_CYC));

  always_comb begin
    run_d = run_q;
    if (bad) run_d = '0;
    else if (good && run_q != SW'(QUAL_CNT)) run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (drop) locked_q <= 1'b0;
      else if (good && run_d >= SW'(QUAL_CNT)) locked_q <= 1'b1;
    end
  end

  assign locked = locked_q;

endmodule

// File: rtl/pfdl_section.sv
module pfdl_section
  import pfdl_pkg::*;
#(
  parameter int LOSS_CYC = 4,
  parameter int QUAL_CYC = 8,
  parameter int QUAL_CNT = 3,
  parameter int WAKE_CAP = 2,
  localparam int CW = cnt_width(QUAL_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ref_stb,
  input  logic fb_stb,
  input  logic pol,
  output logic oe,
  output logic lvl,
  output logic locked,
  output logic done,
  output logic drop,
  output logic rep_lock
);

  logic          up, dn, active;
  logic [CW-1:0] err_cnt, done_width;
  logic          clipped_q;

  pfdl_phase_det #(.SAT_MAX(QUAL_CYC)) u_det (
    .clk(clk), .rst_n(rst_n), .en(en),
    .ref_stb(ref_stb), .fb_stb(fb_stb),
    .up(up), .dn(dn), .active(active),
    .err_cnt(err_cnt), .done(done), .done_width(done_width)
  );

  pfdl_lock_qual #(.LOSS_CYC(LOSS_CYC), .QUAL_CYC(QUAL_CYC), .QUAL_CNT(QUAL_CNT)) u_qual (
    .clk(clk), .rst_n(rst_n), .en(en), .active(active),
    .err_cnt(err_cnt), .done(done), .done_width(done_width),
    .locked(locked), .drop(drop)
  );

  // Clip window armed by reset and by sleep, released by the first finished comparison.
  always_ff @(posedge clk) begin
    if (!rst_n || !en) clipped_q <= 1'b1;
    else if (done)     clipped_q <= 1'b0;
  end

  assign oe       = en && active && wake_pass(clipped_q, int'(err_cnt), WAKE_CAP);
  assign lvl      = oe && pump_level(up, dn, pol);
  assign rep_lock = locked || !en;

endmodule

// File: rtl/pfd_lock_pair.sv
module pfd_lock_pair #(
  parameter int NSEC     = 2,
  parameter int LOSS_CYC = 4,
  parameter int QUAL_CYC = 8,
  parameter int QUAL_CNT = 3,
  parameter int WAKE_CAP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEC-1:0] ref_stb,
  input  logic [NSEC-1:0] fb_stb,
  input  logic [NSEC-1:0] pol,
  input  logic [NSEC-1:0] awake,
  output logic [NSEC-1:0] pump_oe,
  output logic [NSEC-1:0] pump_lvl,
  output logic            lock_all
);

  // Per-section events brought out for the checker.
  logic [NSEC-1:0] sec_locked;
  logic [NSEC-1:0] sec_done;
  logic [NSEC-1:0] sec_drop;
  logic [NSEC-1:0] sec_rep;

  for (genvar i = 0; i < NSEC; i++) begin : g_sec
    pfdl_section #(
      .LOSS_CYC(LOSS_CYC), .QUAL_CYC(QUAL_CYC),
      .QUAL_CNT(QUAL_CNT), .WAKE_CAP(WAKE_CAP)
    ) u_sec (
      .clk(clk), .rst_n(rst_n), .en(awake[i]),
      .ref_stb(ref_stb[i]), .fb_stb(fb_stb[i]), .pol(pol[i]),
      .oe(pump_oe[i]), .lvl(pump_lvl[i]),
      .locked(sec_locked[i]), .done(sec_done[i]),
      .drop(sec_drop[i]), .rep_lock(sec_rep[i])
    );
  end

  assign lock_all = &sec_rep;

endmodule

// File: rtl/pfdl_checks.sv
module pfdl_checks #(
  parameter int NSEC = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSEC-1:0] awake,
  input logic [NSEC-1:0] pump_oe,
  input logic [NSEC-1:0] pump_lvl,
  input logic            lock_all,
  input logic [NSEC-1:0] sec_locked,
  input logic [NSEC-1:0] sec_done,
  input logic [NSEC-1:0] sec_drop
);

  // R9
  oe_needs_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_oe & ~awake) == '0);

  // R4
  lvl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_lvl & ~pump_oe) == '0);

  // R6
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sec_drop) |=> ((sec_locked & $past(sec_drop)) == '0));

  // R7
  lock_rise_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_locked & ~$past(sec_locked) & ~$past(sec_done)) == '0);

  // R9
  sleep_holds_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~$past(awake) & (sec_locked ^ $past(sec_locked))) == '0);

  // R8
  all_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awake == '0) |-> lock_all);

endmodule

bind pfd_lock_pair pfdl_checks #(.NSEC(NSEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .awake(awake), .pump_oe(pump_oe),
  .pump_lvl(pump_lvl), .lock_all(lock_all), .sec_locked(sec_locked),
  .sec_done(sec_done), .sec_drop(sec_drop)
);

// File: tb/pfd_lock_pair_bench.sv
module pfd_lock_pair_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ref_stb = '0;
  logic [1:0] fb_stb = '0;
  logic [1:0] pol = 2'b11;
  logic [1:0] awake = '0;
  logic [1:0] pump_oe, pump_lvl;
  logic       lock_all;

  int n_chk = 0;
  int n_bad = 0;

  pfd_lock_pair u_pfd_lock_pair (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
    .pol(pol), .awake(awake), .pump_oe(pump_oe), .pump_lvl(pump_lvl),
    .lock_all(lock_all)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic       ref_lead;
    logic [3:0] gap;
    logic       pl;
    logic [3:0] vis;
    logic       lvl;
    logic       lock;
  } vec_t;

  // Section 0 awake, section 1 asleep (counts as locked).
  localparam vec_t VEC [12] = '{
    '{1'b1, 4'd5, 1'b1, 4'd2, 1'b1, 1'b0},  // clipped first comparison
    '{1'b1, 4'd3, 1'b1, 4'd3, 1'b1, 1'b0},
    '{1'b0, 4'd2, 1'b1, 4'd2, 1'b0, 1'b1},  // third small error locks
    '{1'b1, 4'd0, 1'b1, 4'd0, 1'b0, 1'b1},
    '{1'b1, 4'd1, 1'b0, 4'd1, 1'b0, 1'b1},
    '{1'b0, 4'd3, 1'b0, 4'd3, 1'b1, 1'b1},
    '{1'b1, 4'd6, 1'b1, 4'd6, 1'b1, 1'b0},
    '{1'b1, 4'd9, 1'b1, 4'd9, 1'b1, 1'b0},
    '{1'b0, 4'd1, 1'b1, 4'd1, 1'b0, 1'b0},
    '{1'b1, 4'd2, 1'b1, 4'd2, 1'b1, 1'b0},
    '{1'b0, 4'd7, 1'b0, 4'd7, 1'b1, 1'b0},
    '{1'b1, 4'd1, 1'b1, 4'd1, 1'b1, 1'b1}
  };

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Apply a one-cycle strobe pair, then land 5 ns after the edge.
  task automatic drive(input int s, input bit r, input bit f);
    ref_stb[s] = r;
    fb_stb[s]  = f;
    @(posedge clk);
    #5;
    ref_stb[s] = 1'b0;
    fb_stb[s]  = 1'b0;
  endtask

  task automatic compare(input int s, input bit ref_lead, input int d,
                         output int vis, output bit lvl_seen);
    vis = 0;
    lvl_seen = 1'b0;
    if (d == 0) begin
      drive(s, 1'b1, 1'b1);
      if (pump_oe[s]) vis++;
    end else begin
      drive(s, ref_lead, !ref_lead);
      if (pump_oe[s]) begin vis++; lvl_seen = pump_lvl[s]; end
      for (int k = 1; k < d; k++) begin
        drive(s, 1'b0, 1'b0);
        if (pump_oe[s]) begin vis++; lvl_seen = pump_lvl[s]; end
      end
      drive(s, !ref_lead, ref_lead);
      if (pump_oe[s]) vis++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int  vis;
    bit  lv;
    repeat (4) @(posedge clk);
    #5;
    // R1 / R8: in reset with both asleep
    check(pump_oe == 2'b00, "R1", pump_oe, 0);
    check(lock_all == 1'b1, "R8", lock_all, 1);
    rst_n = 1'b1;
    awake[0] = 1'b1;
    @(posedge clk); #5;
    check(pump_oe == 2'b00 && pump_lvl == 2'b00, "R1", {pump_oe, pump_lvl}, 0);
    check(lock_all == 1'b0, "R1", lock_all, 0);

    // Vector table: R2 R3 R4 R7 R10
    for (int v = 0; v < 12; v++) begin
      pol[0] = VEC[v].pl;
      compare(0, VEC[v].ref_lead, int'(VEC[v].gap), vis, lv);
      check(vis == int'(VEC[v].vis), "R4_R10 width", vis, VEC[v].vis);
      check(lv == VEC[v].lvl, VEC[v].pl ? "R2 level" : "R3 level", lv, VEC[v].lvl);
      check(lock_all == VEC[v].lock, "R7 lock", lock_all, VEC[v].lock);
      drive(0, 1'b0, 1'b0);
    end

    // R9: sleep in mid-pulse while locked
    pol[0] = 1'b1;
    drive(0, 1'b1, 1'b0);
    check(pump_oe[0] == 1'b1, "R9 pre", pump_oe[0], 1);
    awake[0] = 1'b0;
    #1;
    check(pump_oe[0] == 1'b0, "R9 float", pump_oe[0], 0);
    drive(0, 1'b1, 1'b0);
    check(pump_oe[0] == 1'b0, "R9 ignore", pump_oe[0], 0);
    drive(0, 1'b0, 1'b1);
    check(lock_all == 1'b1, "R9 asleep", lock_all, 1);
    awake[0] = 1'b1;
    #1;
    check(lock_all == 1'b1, "R9 held", lock_all, 1);
    drive(0, 1'b0, 1'b0);
    check(pump_oe[0] == 1'b0, "R9 aborted", pump_oe[0], 0);

    // R10: only first comparison after wake clipped
    compare(0, 1'b1, 5, vis, lv);
    check(vis == 2, "R10 clipped", vis, 2);
    check(lock_all == 1'b0, "R6 end", lock_all, 0);
    compare(0, 1'b1, 5, vis, lv);
    check(vis == 5, "R10 released", vis, 5);
    compare(0, 1'b0, 1, vis, lv);
    check(lock_all == 1'b1, "R7 relock", lock_all, 1);

    // R6: drop in mid-pulse at the edge after 4 driven cycles
    drive(0, 1'b1, 1'b0);
    drive(0, 1'b0, 1'b0);
    drive(0, 1'b0, 1'b0);
    drive(0, 1'b0, 1'b0);
    check(lock_all == 1'b1, "R6 before", lock_all, 1);
    drive(0, 1'b0, 1'b0);
    check(lock_all == 1'b0, "R6 drop", lock_all, 0);
    drive(0, 1'b0, 1'b1);

    // R5: repeated leading strobe keeps one pulse
    vis = 0;
    drive(0, 1'b1, 1'b0); if (pump_oe[0]) vis++;
    drive(0, 1'b0, 1'b0); if (pump_oe[0]) vis++;
    drive(0, 1'b1, 1'b0); if (pump_oe[0]) vis++;
    drive(0, 1'b0, 1'b0); if (pump_oe[0]) vis++;
    drive(0, 1'b0, 1'b1); if (pump_oe[0]) vis++;
    check(vis == 4, "R5 width", vis, 4);
    compare(0, 1'b1, 1, vis, lv);
    check(lock_all == 1'b1, "R7 run kept", lock_all, 1);

    // R8: second section wakes unlocked, then qualifies
    awake[1] = 1'b1;
    #1;
    check(lock_all == 1'b0, "R8 one unlocked", lock_all, 0);
    compare(1, 1'b1, 1, vis, lv);
    check(vis == 1 && lv == 1'b1, "R2 sec1", vis, 1);
    compare(1, 1'b0, 1, vis, lv);
    check(lock_all == 1'b0, "R7 sec1 two", lock_all, 0);
    compare(1, 1'b1, 1, vis, lv);
    check(lock_all == 1'b1, "R8 both locked", lock_all, 1);

    summary();
    $finish;
  end

endmodule